// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects eight interrupt request lines and presents them to a host processor as one interrupt output. Each input is synchronised to the block clock. It is latched as pending either on a rising edge or, in level mode, for as long as the line is held high. A host-writable mask decides which pending requests may compete for service. A fixed-priority resolver then compares the best unmasked request against the requests already in service. The interrupt output is raised only when the new request outranks all of those still in service.

The host reaches the block through a small register port: an active-low chip select, active-low read and write strobes, and one address bit. With the address bit low, a write is a command byte: the low three bits hold an opcode and the upper five bits hold an operand. With the address bit high, a write loads the mask. When the host acknowledges, it pulls the single-cycle acknowledge strobe low. In that cycle the block drives an 8-bit vector on the read data bus and moves the winning request into service. That request stays in service until the host issues a non-specific end-of-interrupt command.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request and in-service state is empty, all eight inputs are masked (mask reads 8'hFF), the vector base is zero, edge mode is selected and `intOut` is low.
- R2: In edge mode a request bit is set only by a low-to-high transition of its synchronised input. It stays set after the input falls. An input held high after its acknowledge does not set the bit again.
- R3: In level mode each request bit follows its synchronised input, so a request disappears when its line falls before service.
- R4: A mask bit of 1 keeps its input from raising `intOut`, and from being selected on acknowledge. The request bit itself stays latched and readable.
- R5: Priority is fixed: input 0 is highest and input 7 is lowest. The acknowledge selects the lowest-numbered eligible request.
- R6: `intOut` is high only when there is an unmasked pending request whose number is lower than every input currently in service.
- R7: During an acknowledge with `intOut` high, `dataOut` carries {base, winning input number}: base in bits 7:3 and input number in bits 2:0. Command opcode 3'd1 loads the base from `dataIn[7:3]`.
- R8: The clock edge that samples an acknowledge with `intOut` high does three things: it clears the winning request bit, sets its in-service bit, and brings `intOut` to its re-evaluated value from the next cycle.
- R9: Command opcode 3'd2 (non-specific end of interrupt) clears only the lowest-numbered in-service bit.
- R10: An acknowledge while `intOut` is low returns {base, 3'd7} and changes no state.
- R11: A read with `addr0`=0 returns the request bits. A read with `addr0`=1 returns the mask. With neither a read nor an acknowledge active, `dataOut` is 8'h00.
- R12: Opcode 3'd3 selects edge mode and opcode 3'd4 selects level mode. Command opcodes 0, 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select for register access |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe, sampled on the clock edge |
| addr0 | input | 1 | Register select: 0 = command / request bits, 1 = mask |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data or acknowledge vector |
| ackN | input | 1 | Active-low single-cycle interrupt acknowledge |
| irqIn | input | 8 | Asynchronous interrupt request lines |
| intOut | output | 1 | Interrupt output toward the host |

## Verification
The checker module watches the in-service bookkeeping on every cycle. It confirms that in-service bits appear only on an accepted acknowledge, at most one at a time, and never for a masked input. It confirms that they disappear only on an end-of-interrupt command, that the acknowledged number lands in service, and that a refused acknowledge returns 7 and leaves the in-service set stable. Other behaviour needs the bench's scenarios to show it: the edge and level latching through the synchroniser, the nested blocking and release of lower-priority requests, the vector bases, and the command opcodes that are ignored.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NumIrq = 8;
  localparam int IdxW   = $clog2(NumIrq);
  localparam int VecW   = 8;
  localparam int BaseW  = VecW - IdxW;

  localparam logic [IdxW-1:0] OpBase  = 3'd1;
  localparam logic [IdxW-1:0] OpEoi   = 3'd2;
  localparam logic [IdxW-1:0] OpEdge  = 3'd3;
  localparam logic [IdxW-1:0] OpLevel = 3'd4;

  typedef struct packed {
    logic maskWr;
    logic baseWr;
    logic eoi;
    logic modeWr;
    logic modeLevel;
    logic ack;
    logic rdEn;
    logic rdMask;
  } ctrlStrobe_t;

  function automatic logic [IdxW-1:0] lowestIdx(input logic [NumIrq-1:0] v);
    logic [IdxW-1:0] r;
    r = '0;
    for (int k = NumIrq - 1; k >= 0; k--) begin
      if (v[k]) r = IdxW'(k);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic             addr0,
  input  logic             ackN,
  input  logic [VecW-1:0]  dataIn,
  output ctrlStrobe_t      strb
);
  logic            wrHit;
  logic [IdxW-1:0] opCode;

  assign wrHit  = !csN && !wrN;
  assign opCode = dataIn[IdxW-1:0];

  always_comb begin
    strb           = '0;
    strb.ack       = !ackN;
    strb.rdEn      = !csN && !rdN;
    strb.rdMask    = addr0;
    strb.maskWr    = wrHit && addr0;
    if (wrHit && !addr0) begin
      strb.baseWr    = (opCode == OpBase);
      strb.eoi       = (opCode == OpEoi);
      strb.modeWr    = (opCode == OpEdge) || (opCode == OpLevel);
      strb.modeLevel = (opCode == OpLevel);
    end
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic [VecW-1:0]   wrData,
  input  logic [NumIrq-1:0] irqIn,
  output logic              intOut,
  output logic [VecW-1:0]   dataOut,
  output logic [NumIrq-1:0] irrQ,
  output logic [NumIrq-1:0] isrQ,
  output logic [NumIrq-1:0] maskQ
);
  logic [NumIrq-1:0] syncLvl, prevQ, rise, pending;
  logic [NumIrq-1:0] ackClr, eoiClr, irrNext, isrNext;
  logic [BaseW-1:0]  baseQ;
  logic              levelQ;
  logic [IdxW-1:0]   winIdx, isrTop;
  logic              pendAny, isrAny, ackHit;
  logic [VecW-1:0]   vector;

  for (genvar i = 0; i < NumIrq; i++) begin : g_sync
    logic [SyncStages-1:0] stg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[SyncStages-2:0], irqIn[i]};
    end
    assign syncLvl[i] = stg[SyncStages-1];
  end

  assign rise    = syncLvl & ~prevQ;
  assign pending = irrQ & ~maskQ;
  assign pendAny = |pending;
  assign isrAny  = |isrQ;
  assign winIdx  = lowestIdx(pending);
  assign isrTop  = lowestIdx(isrQ);

  assign intOut  = pendAny && (!isrAny || (winIdx < isrTop));
  assign ackHit  = strb.ack && intOut;
  assign ackClr  = ackHit ? (NumIrq'(1) << winIdx) : '0;
  assign eoiClr  = (strb.eoi && isrAny) ? (NumIrq'(1) << isrTop) : '0;

  assign irrNext = levelQ ? (syncLvl & ~ackClr) : ((irrQ & ~ackClr) | rise);
  assign isrNext = (isrQ & ~eoiClr) | ackClr;

  assign vector  = {baseQ, ackHit ? winIdx : IdxW'(NumIrq - 1)};

  always_comb begin
    if (strb.ack)       dataOut = vector;
    else if (strb.rdEn) dataOut = strb.rdMask ? maskQ : irrQ;
    else                dataOut = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevQ  <= '0;
      irrQ   <= '0;
      isrQ   <= '0;
      maskQ  <= '1;
      baseQ  <= '0;
      levelQ <= 1'b0;
    end else begin
      prevQ <= syncLvl;
      irrQ  <= irrNext;
      isrQ  <= isrNext;
      if (strb.maskWr) maskQ  <= wrData;
      if (strb.baseWr) baseQ  <= wrData[VecW-1:IdxW];
      if (strb.modeWr) levelQ <= strb.modeLevel;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        addr0,
  input  logic [7:0]  dataIn,
  output logic [7:0]  dataOut,
  input  logic        ackN,
  input  logic [7:0]  irqIn,
  output logic        intOut
);
  ctrlStrobe_t       strb;
  logic [NumIrq-1:0] irrQ, isrQ, maskQ;

  irq_ctrl u_ctrl (
    .csN    (csN),
    .rdN    (rdN),
    .wrN    (wrN),
    .addr0  (addr0),
    .ackN   (ackN),
    .dataIn (dataIn),
    .strb   (strb)
  );

  irq_datapath #(.SyncStages(SyncStages)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .wrData  (dataIn),
    .irqIn   (irqIn),
    .intOut  (intOut),
    .dataOut (dataOut),
    .irrQ    (irrQ),
    .isrQ    (isrQ),
    .maskQ   (maskQ)
  );
endmodule

// File: rtl/irq_chk.sv
module irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csN,
  input logic       wrN,
  input logic       addr0,
  input logic       ackN,
  input logic [7:0] dataIn,
  input logic [7:0] dataOut,
  input logic       intOut,
  input logic [7:0] irrQ,
  input logic [7:0] isrQ,
  input logic [7:0] maskQ
);
  logic eoiCmd;
  assign eoiCmd = !csN && !wrN && !addr0 && (dataIn[2:0] == 3'd2);

  // R4
  pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intOut |-> ((irrQ & ~maskQ) != 8'h00));

  // R8
  isr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((isrQ & ~$past(isrQ)) != 8'h00) |-> $past(!ackN && intOut));

  // R8
  isr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isrQ & ~$past(isrQ)));

  // R4
  isr_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((isrQ & ~$past(isrQ) & $past(maskQ)) == 8'h00));

  // R7
  ack_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ackN && intOut) |=> isrQ[$past(dataOut[2:0])]);

  // R10
  spur_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ackN && !intOut) |-> (dataOut[2:0] == 3'd7));

  // R10
  spur_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ackN && !intOut && !eoiCmd) |=> $stable(isrQ));

  // R9
  isr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~isrQ & $past(isrQ)) != 8'h00) |-> $past(eoiCmd));

  // R9
  eoi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~isrQ & $past(isrQ)));
endmodule

bind prio_irq_ctrl irq_chk u_irqChk (
  .clk     (clk),
  .rst_n   (rst_n),
  .csN     (csN),
  .wrN     (wrN),
  .addr0   (addr0),
  .ackN    (ackN),
  .dataIn  (dataIn),
  .dataOut (dataOut),
  .intOut  (intOut),
  .irrQ    (irrQ),
  .isrQ    (isrQ),
  .maskQ   (maskQ)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csN = 1'b1, rdN = 1'b1, wrN = 1'b1, addr0 = 1'b0, ackN = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] irqIn = 8'h00;
  logic [7:0] dataOut;
  logic       intOut;
  int         errs = 0;
  int         checks = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rdN(rdN), .wrN(wrN), .addr0(addr0),
    .dataIn(dataIn), .dataOut(dataOut), .ackN(ackN), .irqIn(irqIn), .intOut(intOut)
  );

  // {irq, mask, expInt, expVec} walked in level mode with base 8'hA0
  localparam logic [24:0] Walk [8] = '{
    {8'h01, 8'h00, 1'b1, 8'hA0},
    {8'h80, 8'h00, 1'b1, 8'hA7},
    {8'h28, 8'h00, 1'b1, 8'hA3},
    {8'h28, 8'h08, 1'b1, 8'hA5},
    {8'hFF, 8'hFF, 1'b0, 8'h00},
    {8'hF0, 8'h1F, 1'b1, 8'hA5},
    {8'h00, 8'h00, 1'b0, 8'h00},
    {8'h81, 8'h7E, 1'b1, 8'hA0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic a, input logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; wrN = 1'b0; addr0 = a; dataIn = d;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1; dataIn = 8'h00;
  endtask

  task automatic regRead(input logic a, output logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; addr0 = a;
    #1 d = dataOut;
    csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic doAck(output logic [7:0] d);
    @(negedge clk);
    ackN = 1'b0;
    #1 d = dataOut;
    @(negedge clk);
    ackN = 1'b1;
    #1;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk);
    irqIn = p;
    idle(2);
    irqIn = 8'h00;
    idle(4);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    regRead(1'b1, v); chk("R1 mask after reset", v, 8'hFF);
    regRead(1'b0, v); chk("R1 requests after reset", v, 8'h00);
    chk("R1 intOut after reset", {7'd0, intOut}, 8'h00);
    #1 chk("R11 idle bus", dataOut, 8'h00);
    doAck(v); chk("R1 R10 spurious vector base zero", v, 8'h07);

    // R2 edge latching
    regWrite(1'b1, 8'h00);
    pulse(8'h04);
    regRead(1'b0, v); chk("R2 pulse latched", v, 8'h04);
    chk("R2 intOut raised", {7'd0, intOut}, 8'h01);
    doAck(v); chk("R2 R7 vector", v, 8'h02);
    regRead(1'b0, v); chk("R8 request cleared by ack", v, 8'h00);
    regWrite(1'b0, 8'h02);
    @(negedge clk); irqIn = 8'h20; idle(4);
    doAck(v); chk("R2 held input vector", v, 8'h05);
    regWrite(1'b0, 8'h02);
    idle(6);
    regRead(1'b0, v); chk("R2 no relatch while high", v, 8'h00);
    chk("R2 intOut stays low", {7'd0, intOut}, 8'h00);
    irqIn = 8'h00; idle(4);

    // R5 R6 R8 R9 nesting
    pulse(8'h08);
    doAck(v); chk("R6 first vector", v, 8'h03);
    chk("R8 intOut dropped after ack", {7'd0, intOut}, 8'h00);
    pulse(8'h20);
    regRead(1'b0, v); chk("R6 lower request pending", v, 8'h20);
    chk("R6 lower request blocked", {7'd0, intOut}, 8'h00);
    pulse(8'h02);
    chk("R6 higher request passes", {7'd0, intOut}, 8'h01);
    doAck(v); chk("R5 nested vector", v, 8'h01);
    regWrite(1'b0, 8'h02); #1;
    chk("R9 one EOI keeps input 3 in service", {7'd0, intOut}, 8'h00);
    regWrite(1'b0, 8'h02); #1;
    chk("R9 second EOI releases input 5", {7'd0, intOut}, 8'h01);
    doAck(v); chk("R9 released vector", v, 8'h05);
    regWrite(1'b0, 8'h02);
    pulse(8'h24);
    doAck(v); chk("R5 two at once picks lower number", v, 8'h02);
    regWrite(1'b0, 8'h02);
    doAck(v); chk("R5 remaining request", v, 8'h05);
    regWrite(1'b0, 8'h02);

    // R12 R7 base and ignored opcodes
    regWrite(1'b0, 8'hA1);
    regWrite(1'b0, 8'hF6);
    regWrite(1'b0, 8'h58);
    regWrite(1'b0, 8'h3F);
    doAck(v); chk("R12 R10 ignored opcodes keep base", v, 8'hA7);
    regWrite(1'b0, 8'h04);

    // R3 level following
    @(negedge clk); irqIn = 8'h40; idle(4);
    regRead(1'b0, v); chk("R3 level high", v, 8'h40);
    irqIn = 8'h00; idle(4);
    regRead(1'b0, v); chk("R3 level follows fall", v, 8'h00);

    // table walk: R4 R5 R6 R7
    for (int n = 0; n < 8; n++) begin
      @(negedge clk); irqIn = Walk[n][24:17];
      regWrite(1'b1, Walk[n][16:9]);
      idle(4);
      regRead(1'b0, v); chk($sformatf("R4 walk %0d request", n), v, Walk[n][24:17]);
      chk($sformatf("R6 walk %0d intOut", n), {7'd0, intOut}, {7'd0, Walk[n][8]});
      if (Walk[n][8]) begin
        doAck(v); chk($sformatf("R7 walk %0d vector", n), v, Walk[n][7:0]);
        regWrite(1'b0, 8'h02);
      end
      irqIn = 8'h00; idle(4);
    end

    // R12 back to edge mode
    regWrite(1'b1, 8'h00);
    regWrite(1'b0, 8'h03);
    @(negedge clk); irqIn = 8'h10; idle(4);
    doAck(v); chk("R12 edge vector", v, 8'hA4);
    idle(4);
    regRead(1'b0, v); chk("R12 edge mode no follow", v, 8'h00);
    regWrite(1'b0, 8'h02);
    irqIn = 8'h00; idle(2);
    finishRun();
  end
endmodule